// File: doc/BRIEF.md
# Sampled Bit-to-Gate Pattern Generator

This block turns an 8-bit code, presented on a parallel input, into eight gate outputs, one for each bit. A slow sampling clock, which arrives as a plain input and is watched by the system clock, sets the update rate. Each rising edge of that sampling clock captures four things: the code, the per-output performance controls, the global mode and the pulse duration. Between edges the outputs never move, except when a trigger pulse expires.

In latch mode each gate holds its level until the next sampling edge. In trigger mode each active gate emits one pulse that lasts a whole number of milliseconds. A prescaler derives a one-millisecond tick from the system clock. Every output can be passed through, muted or inverted, and that choice is applied to the bit before the latch or trigger logic. The code, the controls, the mode and the duration are plain control pins sampled on an edge, so the block has no valid/ready handshake and exerts no back-pressure.

Top module: `sampled_gate_array`

## Requirements
- R1: The inputs are captured only when `samp_clk_i` goes from low to high. Holding it high or low captures nothing. Outputs take the new values on the second rising edge of `clk` at which `samp_clk_i` is seen high.
- R2: `gate_o[n]` follows bit n of the captured code, so `gate_o[0]` carries the least significant bit. For example, code 0x66 drives outputs 1, 2, 5 and 6 high.
- R3: Codes are offset binary. 0x00 (full negative) drives all gates low, 0x80 (mid-scale) drives only `gate_o[7]` high, and 0xFF (full positive) drives all gates high.
- R4: With `mode_trig_i`=0 captured, a gate holds its level until the next capture. A gate that is high and recaptured high shows no low cycle.
- R5: With `mode_trig_i`=1 captured, a gate whose effective bit is 1 goes high at the capture and stays high for exactly D×`TICK_DIV` clock cycles, where D is the captured duration. The millisecond prescaler restarts at each capture.
- R6: The duration `dur_ms_i` is clamped to the range 1..50. Value 0 acts as 1, and values 51..63 act as 50.
- R7: The control for output n is `perf_ctl_i[2n+1:2n]`. 00 is normal, 01 forces the output low, 10 inverts the bit, and 11 acts as normal.
- R8: Changes on `perf_ctl_i`, `code_i`, `mode_trig_i` and `dur_ms_i` between sampling edges have no effect on `gate_o`.
- R9: A capture during a running pulse restarts the full duration for each output whose effective bit is 1. It drives low at once each output whose effective bit is 0. When a capture falls in the cycle in which a pulse would expire, the capture wins.
- R10: Muting and inversion act before the trigger logic. An inverted output in trigger mode fires when its raw bit is 0.
- R11: Synchronous reset `rst` drives all gates low and clears all pulse state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_clk_i | input | 1 | Sampling clock; its rising edge captures the inputs |
| code_i | input | 8 | Offset-binary code to show on the gates |
| mode_trig_i | input | 1 | 0 = latch, 1 = timed trigger pulses |
| dur_ms_i | input | 6 | Pulse length in milliseconds, clamped to 1..50 |
| perf_ctl_i | input | 16 | Two bits per output: normal, mute, invert |
| gate_o | output | 8 | Gate outputs, bit n for output n |

## Verification
A new capture strobe and the final millisecond tick of a running pulse can land on the same clock edge. The strobe must restart the pulse, and the tick must not clear the gate. The bench first starts a two-millisecond pulse. It then counts clock cycles so that the next sampling edge's strobe lands exactly on the expiring tick. It judges the result by sampling the gate every cycle: the gate must never go low, and after the restart it must stay high for a further full duration.

// File: rtl/sga_pkg.sv
package sga_pkg;
  typedef enum logic [1:0] {
    PERF_PASS = 2'b00,
    PERF_MUTE = 2'b01,
    PERF_INV  = 2'b10,
    PERF_RSVD = 2'b11
  } perf_e;
endpackage

// File: rtl/sga_ms_tick.sv
module sga_ms_tick #(
  parameter int TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);
  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || restart_i) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST) && !restart_i;

      // R5
      tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end else begin : g_nodiv
      assign tick_o = !restart_i;
    end
  endgenerate
endmodule

// File: rtl/sga_capture.sv
module sga_capture #(
  parameter int CODE_W  = 8,
  parameter int DUR_W   = 6,
  parameter int DUR_MIN = 1,
  parameter int DUR_MAX = 50
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  samp_i,
  input  logic [CODE_W-1:0]     code_i,
  input  logic [2*CODE_W-1:0]   perf_i,
  input  logic                  mode_i,
  input  logic [DUR_W-1:0]      dur_i,
  output logic                  stb_o,
  output logic [CODE_W-1:0]     code_o,
  output logic [2*CODE_W-1:0]   perf_o,
  output logic                  mode_o,
  output logic [DUR_W-1:0]      dur_o
);
  localparam logic [DUR_W-1:0] LO = DUR_W'(DUR_MIN);
  localparam logic [DUR_W-1:0] HI = DUR_W'(DUR_MAX);

  logic prev_q;
  logic rise;
  logic [DUR_W-1:0] dur_clamped;

  assign rise = samp_i && !prev_q;

  always_comb begin
    if (dur_i < LO)      dur_clamped = LO;
    else if (dur_i > HI) dur_clamped = HI;
    else                 dur_clamped = dur_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      stb_o  <= 1'b0;
      code_o <= '0;
      perf_o <= '0;
      mode_o <= 1'b0;
      dur_o  <= LO;
    end else begin
      prev_q <= samp_i;
      stb_o  <= rise;
      if (rise) begin
        code_o <= code_i;
        perf_o <= perf_i;
        mode_o <= mode_i;
        dur_o  <= dur_clamped;
      end
    end
  end

  // R1
  capture_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_q || !samp_i) |=> ($stable(code_o) && $stable(perf_o) && !stb_o));

  // R6
  dur_range_chk: assert property (@(posedge clk) disable iff (rst)
    (dur_o >= LO) && (dur_o <= HI));
endmodule

// File: rtl/sga_gate_lane.sv
module sga_gate_lane
  import sga_pkg::*;
#(
  parameter int DUR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_stb_i,
  input  logic             bit_i,
  input  perf_e            perf_i,
  input  logic             trig_mode_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             tick_i,
  output logic             gate_o
);
  logic             eff;
  logic             gate_q;
  logic [DUR_W-1:0] cnt_q;

  always_comb begin
    case (perf_i)
      PERF_MUTE: eff = 1'b0;
      PERF_INV:  eff = ~bit_i;
      default:   eff = bit_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cap_stb_i) begin
      gate_q <= eff;
      cnt_q  <= (trig_mode_i && eff) ? dur_i : '0;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == DUR_W'(1)) gate_q <= 1'b0;
    end
  end

  assign gate_o = gate_q;

  // R7
  mute_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_stb_i && perf_i == PERF_MUTE) |=> !gate_q);

  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_stb_i && !tick_i) |=> $stable(gate_q));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_stb_i && !trig_mode_i) |=> $stable(gate_q));

  // R5
  pulse_has_count_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> gate_q);
endmodule

// File: rtl/sampled_gate_array.sv
module sampled_gate_array
  import sga_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int DUR_W    = 6,
  parameter int DUR_MIN  = 1,
  parameter int DUR_MAX  = 50,
  parameter int TICK_DIV = 125000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                samp_clk_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                mode_trig_i,
  input  logic [DUR_W-1:0]    dur_ms_i,
  input  logic [2*CODE_W-1:0] perf_ctl_i,
  output logic [CODE_W-1:0]   gate_o
);
  logic                cap_stb;
  logic [CODE_W-1:0]   code_q;
  logic [2*CODE_W-1:0] perf_q;
  logic                mode_q;
  logic [DUR_W-1:0]    dur_q;
  logic                tick;

  sga_capture #(
    .CODE_W(CODE_W), .DUR_W(DUR_W), .DUR_MIN(DUR_MIN), .DUR_MAX(DUR_MAX)
  ) u_cap (
    .clk(clk), .rst(rst), .samp_i(samp_clk_i), .code_i(code_i),
    .perf_i(perf_ctl_i), .mode_i(mode_trig_i), .dur_i(dur_ms_i),
    .stb_o(cap_stb), .code_o(code_q), .perf_o(perf_q),
    .mode_o(mode_q), .dur_o(dur_q)
  );

  sga_ms_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .restart_i(cap_stb), .tick_o(tick)
  );

  generate
    for (genvar g = 0; g < CODE_W; g++) begin : g_lane
      sga_gate_lane #(.DUR_W(DUR_W)) u_lane (
        .clk(clk), .rst(rst), .cap_stb_i(cap_stb), .bit_i(code_q[g]),
        .perf_i(perf_e'(perf_q[2*g +: 2])), .trig_mode_i(mode_q),
        .dur_i(dur_q), .tick_i(tick), .gate_o(gate_o[g])
      );
    end
  endgenerate

  // R11
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (gate_o == '0));
endmodule

// File: tb/test_sampled_gate_array.sv
module test_sampled_gate_array;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        samp = 1'b0;
  logic [7:0]  code = '0;
  logic        mode = 1'b0;
  logic [5:0]  dur = 6'd1;
  logic [15:0] ctl = '0;
  logic [7:0]  gate;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sampled_gate_array #(.TICK_DIV(DIV)) i_sampled_gate_array (
    .clk(clk), .rst(rst), .samp_clk_i(samp), .code_i(code),
    .mode_trig_i(mode), .dur_ms_i(dur), .perf_ctl_i(ctl), .gate_o(gate)
  );

  // {code, ctl, expected gates}, latch mode
  localparam logic [31:0] VEC [9] = '{
    {8'h00, 16'h0000, 8'h00},   // R3
    {8'h80, 16'h0000, 8'h80},   // R3
    {8'hFF, 16'h0000, 8'hFF},   // R3
    {8'h66, 16'h0000, 8'h66},   // R2
    {8'h01, 16'h0000, 8'h01},   // R2
    {8'hFF, 16'h8001, 8'h7E},   // R7
    {8'h00, 16'hAAAA, 8'hFF},   // R7
    {8'h0F, 16'hFFFF, 8'h0F},   // R7
    {8'h3C, 16'h0052, 8'h31}    // R7
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a negedge; returns after the update edge
  task automatic capture(input logic [7:0] c, input logic [15:0] p,
                         input logic m, input logic [5:0] d);
    code = c; ctl = p; mode = m; dur = d; samp = 1'b1;
    @(negedge clk); samp = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts negedges (current included) where gate bit is high
  task automatic count_high(input int idx, output int n);
    n = 0;
    while (gate[idx] && n < 400) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic lowseen;
    wait_neg(3);
    check("R11 reset state", gate, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      capture(VEC[i][31:24], VEC[i][23:8], 1'b0, 6'd1);
      check($sformatf("R2/R3/R7 vector %0d", i), gate, VEC[i][7:0]);
    end

    // R1: hold sampling clock high, no recapture
    code = 8'h34; ctl = '0; samp = 1'b1;
    wait_neg(2);
    check("R1 edge capture latency", gate, 8'h34);
    code = 8'h56;
    wait_neg(5);
    check("R1 held high no capture", gate, 8'h34);
    samp = 1'b0;
    wait_neg(5);
    check("R1 falling edge no capture", gate, 8'h34);

    // R8: changes between edges ignored
    ctl = 16'h5555; mode = 1'b1; dur = 6'd2; code = 8'h00;
    wait_neg(20);
    check("R8 mid-interval changes ignored", gate, 8'h34);

    // R4: high recaptured high, no low cycle
    capture(8'hFF, 16'h0, 1'b0, 6'd1);
    code = 8'hFF; samp = 1'b1;
    lowseen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      samp = 1'b0;
      if (gate != 8'hFF) lowseen = 1'b1;
    end
    check("R4 latch no glitch", lowseen, 0);
    wait_neg(30);
    check("R4 latch holds", gate, 8'hFF);

    // R5: trigger pulse length
    capture(8'h05, 16'h0, 1'b1, 6'd3);
    check("R5 trigger pattern", gate, 8'h05);
    count_high(0, n);
    check("R5 pulse length 3ms", n, 3 * DIV);
    check("R5 pulse ends low", gate, 8'h00);

    // R6: clamping
    capture(8'h01, 16'h0, 1'b1, 6'd0);
    count_high(0, n);
    check("R6 duration 0 clamps to 1", n, 1 * DIV);
    capture(8'h01, 16'h0, 1'b1, 6'd63);
    count_high(0, n);
    check("R6 duration 63 clamps to 50", n, 50 * DIV);

    // R10: inverted zero fires
    capture(8'h00, 16'h0008, 1'b1, 6'd2);
    check("R10 inverted bit fires", gate, 8'h02);
    count_high(1, n);
    check("R10 inverted pulse length", n, 2 * DIV);

    // R9: retrigger restarts high, clears low
    capture(8'h03, 16'h0, 1'b1, 6'd5);
    wait_neg(8);
    capture(8'h01, 16'h0, 1'b1, 6'd5);
    check("R9 retrigger clears low output", gate, 8'h01);
    count_high(0, n);
    check("R9 retrigger restarts length", n, 5 * DIV);

    // R9: capture coincides with expiring tick
    capture(8'h01, 16'h0, 1'b1, 6'd2);
    lowseen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!gate[0]) lowseen = 1'b1;
    end
    capture(8'h01, 16'h0, 1'b1, 6'd2);
    if (!gate[0]) lowseen = 1'b1;
    check("R9 collision no low cycle", lowseen, 0);
    count_high(0, n);
    check("R9 collision restarted length", n, 2 * DIV);

    // R11: reset mid-pulse
    capture(8'hFF, 16'h0, 1'b1, 6'd10);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 reset clears pulse", gate, 8'h00);
    wait_neg(60);
    check("R11 stays low after reset", gate, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule